// File: doc/BRIEF.md
# Relative Branch Resolver

This unit settles relative control transfers for an 8-bit accumulator processor. One start pulse hands it an opcode byte, a signed 8-bit displacement, the current 16-bit program counter, the N and Z flags and, for compare-and-branch forms, the accumulator, the index register and the fetched memory operand. It returns the next program counter, a taken flag and the cycle count of the instruction. It then raises a done pulse in the final cycle of that count.

For the subroutine-call opcode the unit also saves the return address. It writes the return address to the stack one byte at a time through a byte-wide write port and steps a 16-bit stack pointer down once per byte. The call sequence drives that port and stack pointer. The unit never writes a condition flag. The caller fetches operands and runs every other instruction.

Top module: `branch_resolver`

## Requirements
- R1: Opcode 0x26 is taken when Z=0 and opcode 0x2A is taken when N=0. A taken branch goes to PC+2+rel and an untaken one to PC+2. Both opcodes take 3 cycles.
- R2: Opcode 0x20 is always taken, to PC+2+rel. Opcode 0x21 is never taken and gives PC+2. Both take 3 cycles.
- R3: The compare-and-branch opcodes 0x31, 0x41, 0x61 and 0x71 compare the accumulator, and 0x51 compares the index register. With the page2 input high, 0x61 is the stack-offset form and compares the accumulator. Each is taken when the register minus the operand is 0x00. The target is PC+base+rel, or PC+base when not taken. The base is 3 for 0x31, 0x41, 0x51 and 0x61, 2 for 0x71 and 4 for the stack-offset form.
- R4: Compare-and-branch cycle counts are 5 for 0x31 and 0x61, 4 for 0x41, 0x51 and 0x71, and 6 for the stack-offset form.
- R5: Opcode 0xAD takes 4 cycles and is always taken, to PC+2+rel. In cycle 2 it writes byte [7:0] of PC+2 to address SP. In cycle 3 it writes byte [15:8] of PC+2 to address SP-1. The stack pointer output ends at SP-2. No other opcode writes, and for other opcodes the stack pointer output equals the SP input.
- R6: rel is sign-extended to 16 bits, and all PC sums wrap modulo 2^16.
- R7: A start pulse seen while idle begins an operation at that edge. Cycle 1 is the next clock period. done is high for exactly one period, in cycle N, where N is the cycle count. busy stays high from cycle 1 through cycle N.
- R8: start is ignored while busy. It produces no extra done and does not change the outputs of the running operation.
- R9: Any other opcode, including a page2 opcode other than 0x61, is not taken. It gives next PC equal to the input PC and takes 1 cycle.
- R10: After reset, busy, done, wr_en and taken are 0, and next_pc, sp_out and cycles are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | launches one resolution |
| opcode | input | 8 | instruction opcode byte |
| page2 | input | 1 | opcode follows the second-page prefix |
| rel | input | 8 | signed displacement |
| pc_in | input | 16 | PC of the instruction |
| sp_in | input | 16 | stack pointer at start |
| flag_n | input | 1 | negative flag |
| flag_z | input | 1 | zero flag |
| reg_a | input | 8 | accumulator |
| reg_x | input | 8 | index register low byte |
| mem_op | input | 8 | compare operand |
| busy | output | 1 | operation in progress |
| done | output | 1 | final-cycle pulse |
| next_pc | output | 16 | resolved program counter |
| taken | output | 1 | branch taken |
| cycles | output | 3 | cycle count of the instruction |
| wr_en | output | 1 | stack byte write strobe |
| wr_addr | output | 16 | stack write address |
| wr_data | output | 8 | stack write byte |
| sp_out | output | 16 | stack pointer |

## Verification
A corrupted cycle counter shows at once as a done pulse in the wrong period, measured against the start edge. It also shows as a misplaced write strobe in a call. A wrong latched target or taken bit is visible at done of the same operation. A stack pointer that steps wrongly gives a write address off by one at the second byte, or an sp_out other than SP-2 at done. A start accepted while busy shows as an extra done or as changed outputs before the running operation ends.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam logic [7:0] OP_BNZ  = 8'h26;
    localparam logic [7:0] OP_BNN  = 8'h2A;
    localparam logic [7:0] OP_BAL  = 8'h20;
    localparam logic [7:0] OP_BNV  = 8'h21;
    localparam logic [7:0] OP_CALL = 8'hAD;
    localparam logic [7:0] OP_CQD  = 8'h31;
    localparam logic [7:0] OP_CQIA = 8'h41;
    localparam logic [7:0] OP_CQIX = 8'h51;
    localparam logic [7:0] OP_CQO  = 8'h61;
    localparam logic [7:0] OP_CQP  = 8'h71;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_COND = 2'd1,
        K_CMP  = 2'd2,
        K_CALL = 2'd3
    } kind_e;
endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
#(
    parameter int D_W   = 8,
    parameter int CYC_W = 3
) (
    input  logic [7:0]       opcode,
    input  logic             page2,
    input  logic             flag_n,
    input  logic             flag_z,
    input  logic [D_W-1:0]   reg_a,
    input  logic [D_W-1:0]   reg_x,
    input  logic [D_W-1:0]   mem_op,
    output kind_e            kind,
    output logic             take,
    output logic [2:0]       base,
    output logic [CYC_W-1:0] ncyc
);
    logic           use_x;
    logic [D_W-1:0] diff;

    assign diff = (use_x ? reg_x : reg_a) - mem_op;

    always_comb begin
        kind  = K_NONE;
        take  = 1'b0;
        base  = 3'd0;
        ncyc  = CYC_W'(1);
        use_x = 1'b0;
        if (page2) begin
            if (opcode == OP_CQO) begin
                kind = K_CMP; base = 3'd4; ncyc = CYC_W'(6);
            end
        end else begin
            case (opcode)
                OP_BNZ:  begin kind = K_COND; base = 3'd2; ncyc = CYC_W'(3); take = !flag_z; end
                OP_BNN:  begin kind = K_COND; base = 3'd2; ncyc = CYC_W'(3); take = !flag_n; end
                OP_BAL:  begin kind = K_COND; base = 3'd2; ncyc = CYC_W'(3); take = 1'b1; end
                OP_BNV:  begin kind = K_COND; base = 3'd2; ncyc = CYC_W'(3); take = 1'b0; end
                OP_CALL: begin kind = K_CALL; base = 3'd2; ncyc = CYC_W'(4); take = 1'b1; end
                OP_CQD:  begin kind = K_CMP;  base = 3'd3; ncyc = CYC_W'(5); end
                OP_CQIA: begin kind = K_CMP;  base = 3'd3; ncyc = CYC_W'(4); end
                OP_CQIX: begin kind = K_CMP;  base = 3'd3; ncyc = CYC_W'(4); use_x = 1'b1; end
                OP_CQO:  begin kind = K_CMP;  base = 3'd3; ncyc = CYC_W'(5); end
                OP_CQP:  begin kind = K_CMP;  base = 3'd2; ncyc = CYC_W'(4); end
                default: ;
            endcase
        end
        if (kind == K_CMP) take = (diff == '0);
    end
endmodule

// File: rtl/br_target_add.sv
module br_target_add #(
    parameter int PC_W = 16,
    parameter int D_W  = 8
) (
    input  logic [PC_W-1:0] pc,
    input  logic [2:0]      base,
    input  logic [D_W-1:0]  rel,
    input  logic            use_rel,
    output logic [PC_W-1:0] sum
);
    localparam int EXT_W = PC_W - D_W;

    logic [PC_W-1:0] ofs;

    generate
        if (EXT_W > 0) begin : g_ext
            assign ofs = use_rel ? {{EXT_W{rel[D_W-1]}}, rel} : '0;
        end else begin : g_trunc
            assign ofs = use_rel ? rel[PC_W-1:0] : '0;
        end
    endgenerate

    assign sum = pc + PC_W'(base) + ofs;
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import br_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int D_W   = 8,
    parameter int CYC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic             page2,
    input  logic [D_W-1:0]   rel,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [PC_W-1:0]  sp_in,
    input  logic             flag_n,
    input  logic             flag_z,
    input  logic [D_W-1:0]   reg_a,
    input  logic [D_W-1:0]   reg_x,
    input  logic [D_W-1:0]   mem_op,
    output logic             busy,
    output logic             done,
    output logic [PC_W-1:0]  next_pc,
    output logic             taken,
    output logic [CYC_W-1:0] cycles,
    output logic             wr_en,
    output logic [PC_W-1:0]  wr_addr,
    output logic [D_W-1:0]   wr_data,
    output logic [PC_W-1:0]  sp_out
);
    localparam int NADD = 2;
    localparam logic [CYC_W-1:0] PUSH_LO = CYC_W'(2);
    localparam logic [CYC_W-1:0] PUSH_HI = CYC_W'(3);

    typedef struct packed {
        logic             busy;
        logic [CYC_W-1:0] cnt;
        logic [CYC_W-1:0] ncyc;
        logic [PC_W-1:0]  pc;
        logic             taken;
        logic             call;
        logic [PC_W-1:0]  sp;
        logic [PC_W-1:0]  ret;
    } st_t;

    st_t st_d, st_q;

    kind_e           dk;
    logic            dtake;
    logic [2:0]      dbase;
    logic [CYC_W-1:0] dcyc;
    logic [PC_W-1:0] sums   [NADD];
    logic [2:0]      bases  [NADD];
    logic            userel [NADD];
    logic            last;
    logic            push;

    br_decode #(.D_W(D_W), .CYC_W(CYC_W)) u_dec (
        .opcode(opcode), .page2(page2), .flag_n(flag_n), .flag_z(flag_z),
        .reg_a(reg_a), .reg_x(reg_x), .mem_op(mem_op),
        .kind(dk), .take(dtake), .base(dbase), .ncyc(dcyc)
    );

    // adder 0 forms the target, adder 1 the return address
    assign bases[0]  = dbase;
    assign userel[0] = dtake;
    assign bases[1]  = 3'd2;
    assign userel[1] = 1'b0;

    generate
        for (genvar i = 0; i < NADD; i++) begin : g_add
            br_target_add #(.PC_W(PC_W), .D_W(D_W)) u_add (
                .pc(pc_in), .base(bases[i]), .rel(rel),
                .use_rel(userel[i]), .sum(sums[i])
            );
        end
    endgenerate

    assign last = st_q.busy && (st_q.cnt == st_q.ncyc);
    assign push = st_q.busy && st_q.call &&
                  ((st_q.cnt == PUSH_LO) || (st_q.cnt == PUSH_HI));

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.cnt   = CYC_W'(1);
                st_d.ncyc  = dcyc;
                st_d.pc    = sums[0];
                st_d.taken = dtake;
                st_d.call  = (dk == K_CALL);
                st_d.sp    = sp_in;
                st_d.ret   = sums[1];
            end
        end else begin
            if (last) st_d.busy = 1'b0;
            else      st_d.cnt  = st_q.cnt + CYC_W'(1);
            if (push) st_d.sp   = st_q.sp - PC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = last;
    assign next_pc = st_q.pc;
    assign taken   = st_q.taken;
    assign cycles  = st_q.ncyc;
    assign sp_out  = st_q.sp;
    assign wr_en   = push;
    assign wr_addr = st_q.sp;
    assign wr_data = (st_q.cnt == PUSH_LO) ? st_q.ret[D_W-1:0] : st_q.ret[PC_W-1:PC_W-D_W];
endmodule

// File: rtl/br_checker.sv
module br_checker #(
    parameter int PC_W  = 16,
    parameter int D_W   = 8,
    parameter int CYC_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [PC_W-1:0]  next_pc,
    input logic             taken,
    input logic [CYC_W-1:0] cycles,
    input logic             wr_en,
    input logic [PC_W-1:0]  sp_out
);
    p_wr_in_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy)
        else $error("write strobe outside an operation");

    p_sp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sp_out == $past(sp_out) - PC_W'(1)))
        else $error("stack pointer did not step after a write");

    p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy)
        else $error("done while idle");

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one period");

    p_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy)
        else $error("start not accepted");

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(next_pc) && $stable(taken) && $stable(cycles)))
        else $error("results changed during an operation");
endmodule

bind branch_resolver br_checker #(.PC_W(PC_W), .D_W(D_W), .CYC_W(CYC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .next_pc(next_pc), .taken(taken), .cycles(cycles), .wr_en(wr_en), .sp_out(sp_out)
);

// File: tb/sim_branch_resolver.sv
module sim_branch_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic        page2 = 1'b0;
    logic [7:0]  rel = '0;
    logic [15:0] pc_in = '0;
    logic [15:0] sp_in = '0;
    logic        flag_n = 1'b0;
    logic        flag_z = 1'b0;
    logic [7:0]  reg_a = '0;
    logic [7:0]  reg_x = '0;
    logic [7:0]  mem_op = '0;
    logic        busy, done, taken, wr_en;
    logic [15:0] next_pc, wr_addr, sp_out;
    logic [2:0]  cycles;
    logic [7:0]  wr_data;

    branch_resolver u0 (.*);

    always #5 clk = ~clk;

    typedef struct {
        logic [15:0] pc;
        logic        tk;
        int          ncyc;
        logic [15:0] sp;
        int          t0;
        string       req;
    } exp_t;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
    } wexp_t;

    exp_t  q[$];
    wexp_t wq[$];
    int    nchk = 0, nerr = 0, cyc = 0, pushes = 0, pops = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (q.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
                else begin
                    exp_t e;
                    e = q.pop_front();
                    pops++;
                    chk(next_pc == e.pc, {e.req, " next_pc"}, next_pc, e.pc);
                    chk(taken == e.tk, {e.req, " taken"}, taken, e.tk);
                    chk(cyc - e.t0 == e.ncyc, {e.req, " done cycle"}, cyc - e.t0, e.ncyc);
                    chk(32'(cycles) == e.ncyc, {e.req, " cycles"}, cycles, e.ncyc);
                    chk(sp_out == e.sp, {e.req, " sp_out"}, sp_out, e.sp);
                end
            end
            if (wr_en) begin
                if (wq.size() == 0) chk(1'b0, "R5 unexpected write", wr_addr, 0);
                else begin
                    wexp_t w;
                    w = wq.pop_front();
                    chk(wr_addr == w.addr, "R5 write address", wr_addr, w.addr);
                    chk(wr_data == w.data, "R5 write data", wr_data, w.data);
                end
            end
        end
    end

    function automatic logic [15:0] sx(input logic [7:0] r);
        return {{8{r[7]}}, r};
    endfunction

    task automatic issue(input logic [7:0] op, input logic pg, input logic n, input logic z,
                         input logic [7:0] a, input logic [7:0] x, input logic [7:0] m,
                         input logic [7:0] r, input logic [15:0] pc, input logic [15:0] sp,
                         input string req, input bit poke);
        exp_t e;
        int   base = 0;
        logic tk = 1'b0;
        int   nc = 1;
        logic [7:0] cmpv = a;
        if (pg) begin
            if (op == 8'h61) begin base = 4; nc = 6; tk = (a == m); end
        end else begin
            case (op)
                8'h26: begin base = 2; nc = 3; tk = !z; end
                8'h2A: begin base = 2; nc = 3; tk = !n; end
                8'h20: begin base = 2; nc = 3; tk = 1'b1; end
                8'h21: begin base = 2; nc = 3; tk = 1'b0; end
                8'hAD: begin base = 2; nc = 4; tk = 1'b1; end
                8'h31: begin base = 3; nc = 5; tk = (cmpv == m); end
                8'h41: begin base = 3; nc = 4; tk = (cmpv == m); end
                8'h51: begin base = 3; nc = 4; tk = (x == m); end
                8'h61: begin base = 3; nc = 5; tk = (cmpv == m); end
                8'h71: begin base = 2; nc = 4; tk = (cmpv == m); end
                default: ;
            endcase
        end
        e.pc   = pc + 16'(base) + (tk ? sx(r) : 16'h0);
        e.tk   = tk;
        e.ncyc = nc;
        e.sp   = (op == 8'hAD && !pg) ? sp - 16'd2 : sp;
        e.req  = req;
        if (op == 8'hAD && !pg) begin
            logic [15:0] ret;
            ret = pc + 16'd2;
            wq.push_back('{sp, ret[7:0]});
            wq.push_back('{sp - 16'd1, ret[15:8]});
        end
        @(negedge clk);
        e.t0 = cyc;
        q.push_back(e);
        pushes++;
        opcode = op; page2 = pg; flag_n = n; flag_z = z;
        reg_a = a; reg_x = x; mem_op = m; rel = r; pc_in = pc; sp_in = sp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            opcode = 8'h21; pc_in = 16'hAAAA; sp_in = 16'h5555; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    initial begin
        #2;
        chk(!busy && !done && !wr_en && !taken, "R10 reset flags", {busy, done, wr_en, taken}, 0);
        chk(next_pc == 0 && sp_out == 0 && cycles == 0, "R10 reset values", next_pc, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R10 idle after reset", busy, 0);

        issue(8'h26, 0, 0, 0, 0, 0, 0, 8'h05, 16'h1000, 16'h0100, "R1 ne taken", 0);
        issue(8'h26, 0, 0, 1, 0, 0, 0, 8'h05, 16'h1000, 16'h0100, "R1 ne not taken", 0);
        issue(8'h2A, 0, 0, 0, 0, 0, 0, 8'hF0, 16'h2000, 16'h0100, "R1 pl taken", 0);
        issue(8'h2A, 0, 1, 0, 0, 0, 0, 8'hF0, 16'h2000, 16'h0100, "R1 pl not taken", 0);
        issue(8'h20, 0, 1, 1, 0, 0, 0, 8'h40, 16'h3000, 16'h0100, "R2 always", 0);
        issue(8'h21, 0, 0, 0, 0, 0, 0, 8'h40, 16'h3000, 16'h0100, "R2 never", 0);
        issue(8'h20, 0, 0, 0, 0, 0, 0, 8'h7F, 16'hFFF0, 16'h0100, "R6 wrap up", 0);
        issue(8'h20, 0, 0, 0, 0, 0, 0, 8'h80, 16'h0010, 16'h0100, "R6 wrap down", 0);
        issue(8'h31, 0, 0, 0, 8'h3C, 8'h00, 8'h3C, 8'h10, 16'h4000, 16'h0100, "R3 R4 dir equal", 0);
        issue(8'h31, 0, 0, 0, 8'h3C, 8'h00, 8'h3D, 8'h10, 16'h4000, 16'h0100, "R3 R4 dir unequal", 0);
        issue(8'h41, 0, 0, 0, 8'h99, 8'h00, 8'h99, 8'hFE, 16'h4100, 16'h0100, "R3 R4 imm a", 0);
        issue(8'h51, 0, 0, 0, 8'h11, 8'h22, 8'h22, 8'h08, 16'h4200, 16'h0100, "R3 R4 imm x equal", 0);
        issue(8'h51, 0, 0, 0, 8'h22, 8'h11, 8'h22, 8'h08, 16'h4200, 16'h0100, "R3 imm x ignores a", 0);
        issue(8'h61, 0, 0, 0, 8'h05, 8'h00, 8'h05, 8'h20, 16'h4300, 16'h0100, "R3 R4 ix1 plus", 0);
        issue(8'h71, 0, 0, 0, 8'h05, 8'h00, 8'h05, 8'h20, 16'h4400, 16'h0100, "R3 R4 ix plus", 0);
        issue(8'h61, 1, 0, 0, 8'h07, 8'h00, 8'h07, 8'h20, 16'h4500, 16'h0100, "R3 R4 stack form", 0);
        issue(8'h61, 1, 0, 0, 8'h07, 8'h00, 8'h08, 8'h20, 16'h4500, 16'h0100, "R3 stack form unequal", 0);
        issue(8'hAD, 0, 0, 0, 0, 0, 0, 8'h10, 16'h1234, 16'h00FF, "R5 call", 0);
        issue(8'hAD, 0, 0, 0, 0, 0, 0, 8'hF8, 16'hABFE, 16'h0100, "R5 call carry", 0);
        issue(8'h9D, 0, 0, 0, 0, 0, 0, 8'h10, 16'h5000, 16'h0100, "R9 unknown", 0);
        issue(8'h31, 1, 0, 0, 8'h01, 0, 8'h01, 8'h10, 16'h5100, 16'h0100, "R9 page2 unknown", 0);
        issue(8'hAD, 0, 0, 0, 0, 0, 0, 8'h04, 16'h6000, 16'h0200, "R8 start while busy", 1);
        repeat (4) @(negedge clk);
        chk(q.size() == 0 && pushes == pops, "R8 done count", pops, pushes);
        chk(wq.size() == 0, "R5 all writes seen", wq.size(), 0);
        chk(!busy && !wr_en, "R8 idle after poke", busy, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule